// File: doc/BRIEF.md
# Multistage Trigger Sequencer

This block holds back the start of an output data sequence until a chain of conditions on an external trigger bus has been met. Trigger elements arrive from the sequence stream and are queued in a small internal store. Each element carries a pattern word, a mask word, a flag that marks it as the closing stage of its chain, and a flag that bypasses the wait. The head element is compared against a registered copy of the trigger bus. Stages complete strictly in queue order, and only a closing stage emits a one-cycle launch pulse to the output streamer.

Elements that are still queued after a launch, or that are loaded after one, act as retrigger waits. They stall the running sequence until their own conditions are met. Two status outputs separate the first wait (armed) from later retrigger waits (paused). A synchronous abort empties the queue and returns the block to idle.

Top module: `tseq_trigger_sequencer`

## Requirements
- R1: After reset, or after the cycle in which abort is sampled high, launch, armed and paused are all 0 and no queued element survives.
- R2: A condition holds when ((trig_in ^ pattern) & mask) == 0. Bits of trig_in whose mask bit is 0 have no effect.
- R3: A stage matches only after its condition has been seen false on at least one sampled cycle since it became the head. A level held true across a stage change does not satisfy the new stage. trig_in is registered once: launch is high in the cycle that starts two rising edges after the qualifying value is applied between edges, and it lasts one cycle for each closing element.
- R4: Stages complete in queue order, at most one per clock. A stage whose closing flag is 0 is removed without a launch, and the next stage is not evaluated until it has been removed.
- R5: The two-stage chain (pattern 01, mask 01, not closing) followed by (pattern 10, mask 10, closing) launches only after 01 and then 10 have been presented in that order.
- R6: An element with its bypass flag set completes in its first cycle as head, whatever trig_in is. A closing bypass element loaded into an empty queue gives launch one cycle after the load edge.
- R7: armed goes high at the edge that loads an element while the block is idle. It stays high until the edge that raises launch, and it is never high together with paused.
- R8: After a launch, paused is 1 while further elements are queued or get loaded, and it returns to 0 at the next launch that leaves the queue empty. Chains that alternate between two conditions launch once per closing element.
- R9: Abort takes priority over a completing closing stage in the same cycle: no launch occurs. A push presented in the abort cycle is discarded.
- R10: The queue holds DEPTH elements (default 4). A push while the queue is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort | input | 1 | Synchronous return to idle, discards queued elements |
| elem_push | input | 1 | Load one trigger element this cycle |
| elem_pattern | input | TRIG_W | Pattern word of the pushed element |
| elem_mask | input | TRIG_W | Mask word of the pushed element |
| elem_last | input | 1 | Pushed element closes its chain and launches |
| elem_bypass | input | 1 | Pushed element completes without waiting |
| trig_in | input | TRIG_W | External trigger bus (already synchronous) |
| launch | output | 1 | One-cycle release pulse to the output streamer |
| armed | output | 1 | Waiting for the first launch since idle |
| paused | output | 1 | Waiting on a retrigger after a launch |

## Verification
The sharpest collision is an abort that lands on the very edge where a closing stage would complete. The bench presents the qualifying trigger value and then raises abort one cycle later, so that abort is sampled at the pop edge. It then judges that no launch ever appears and that armed and paused are both low. A second collision puts a push and an abort in the same cycle. The element must be gone, and this is shown by later trigger activity that must stay silent. The scoreboard holds the expected paused level for each launch, so any early, late or extra pulse is flagged where it happens.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

    localparam int TRIG_W = 8;

    typedef logic [TRIG_W-1:0] trig_word_t;

    typedef struct packed {
        logic       last;
        logic       bypass;
        trig_word_t pattern;
        trig_word_t mask;
    } tseq_elem_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ARMED,
        PH_DONE,
        PH_PAUSED
    } tseq_phase_e;

    function automatic logic cond_met(input trig_word_t sample, input tseq_elem_t e);
        return ((sample ^ e.pattern) & e.mask) == '0;
    endfunction

endpackage

// File: rtl/tseq_elem_fifo.sv
module tseq_elem_fifo
    import tseq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       push,
    input  tseq_elem_t push_elem,
    input  logic       pop,
    output tseq_elem_t head,
    output logic       head_valid,
    output logic       multi,
    output logic       push_ok
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    tseq_elem_t       store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             pop_ok;
    logic             full;

    assign full       = (count == FULL_CNT);
    assign head_valid = (count != '0);
    assign multi      = (count > CNT_W'(1));
    assign push_ok    = push && !full;
    assign pop_ok     = pop && head_valid;
    assign head       = store[rd_ptr];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                store[wr_ptr] <= push_elem;
                wr_ptr        <= step(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= step(rd_ptr);
            end
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !head_valid);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (push && full && !flush) |=> (count <= $past(count)));

endmodule

// File: rtl/tseq_stage_eval.sv
module tseq_stage_eval
    import tseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  trig_word_t trig_in,
    input  tseq_elem_t head,
    input  logic       head_valid,
    input  logic       advance,
    output logic       hit
);
    trig_word_t trig_q;
    logic       seen_false;
    logic       cond;

    assign cond = cond_met(trig_q, head);
    assign hit  = head_valid && (head.bypass || (cond && seen_false));

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
        end else begin
            trig_q <= trig_in;
        end
    end

    // A stage needs its condition to go false then true while it is the head.
    always_ff @(posedge clk) begin
        if (rst || flush || advance) begin
            seen_false <= 1'b0;
        end else if (head_valid && !cond) begin
            seen_false <= 1'b1;
        end
    end

    assert_fresh_after_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (advance && !flush) |=> (!hit || head.bypass));

endmodule

// File: rtl/tseq_phase_ctrl.sv
module tseq_phase_ctrl
    import tseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic abort,
    input  logic push_ok,
    input  logic fire_final,
    input  logic remain_after,
    output logic launch,
    output logic armed,
    output logic paused
);
    tseq_phase_e phase_q, phase_d;
    logic        launch_q;

    always_comb begin
        phase_d = phase_q;
        if (fire_final) begin
            phase_d = (remain_after || push_ok) ? PH_PAUSED : PH_DONE;
        end else if (push_ok) begin
            case (phase_q)
                PH_IDLE: phase_d = PH_ARMED;
                PH_DONE: phase_d = PH_PAUSED;
                default: phase_d = phase_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            phase_q  <= PH_IDLE;
            launch_q <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            launch_q <= fire_final;
        end
    end

    assign launch = launch_q;
    assign armed  = (phase_q == PH_ARMED);
    assign paused = (phase_q == PH_PAUSED);

    assert_launch_from_wait_R7: assert property (@(posedge clk) disable iff (rst)
        launch_q |-> $past(phase_q == PH_ARMED || phase_q == PH_PAUSED));

    assert_abort_blocks_launch_R9: assert property (@(posedge clk) disable iff (rst)
        abort |=> !launch_q);

endmodule

// File: rtl/tseq_trigger_sequencer.sv
module tseq_trigger_sequencer
    import tseq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              elem_push,
    input  logic [TRIG_W-1:0] elem_pattern,
    input  logic [TRIG_W-1:0] elem_mask,
    input  logic              elem_last,
    input  logic              elem_bypass,
    input  logic [TRIG_W-1:0] trig_in,
    output logic              launch,
    output logic              armed,
    output logic              paused
);
    tseq_elem_t in_elem;
    tseq_elem_t head;
    logic       head_valid;
    logic       multi;
    logic       push_ok;
    logic       hit;
    logic       fire_final;

    assign in_elem = '{last: elem_last, bypass: elem_bypass,
                       pattern: elem_pattern, mask: elem_mask};

    tseq_elem_fifo #(.DEPTH(DEPTH)) queue_i (
        .clk        (clk),
        .rst        (rst),
        .flush      (abort),
        .push       (elem_push),
        .push_elem  (in_elem),
        .pop        (hit),
        .head       (head),
        .head_valid (head_valid),
        .multi      (multi),
        .push_ok    (push_ok)
    );

    tseq_stage_eval eval_i (
        .clk        (clk),
        .rst        (rst),
        .flush      (abort),
        .trig_in    (trig_in),
        .head       (head),
        .head_valid (head_valid),
        .advance    (hit),
        .hit        (hit)
    );

    assign fire_final = hit && head.last;

    tseq_phase_ctrl phase_i (
        .clk          (clk),
        .rst          (rst),
        .abort        (abort),
        .push_ok      (push_ok),
        .fire_final   (fire_final),
        .remain_after (multi),
        .launch       (launch),
        .armed        (armed),
        .paused       (paused)
    );

    assert_status_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(armed && paused));

endmodule

// File: tb/tseq_trigger_sequencer_tb.sv
`timescale 1ns/1ps
module tseq_trigger_sequencer_tb_top;
    localparam int W = tseq_pkg::TRIG_W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         abort = 1'b0;
    logic         elem_push = 1'b0;
    logic [W-1:0] elem_pattern = '0;
    logic [W-1:0] elem_mask = '0;
    logic         elem_last = 1'b0;
    logic         elem_bypass = 1'b0;
    logic [W-1:0] trig_in = '0;
    logic         launch, armed, paused;

    int n_checks = 0;
    int n_err = 0;
    bit exp_q[$];

    always #2.5 clk = ~clk;

    tseq_trigger_sequencer #(.DEPTH(4)) dut_i (
        .clk(clk), .rst(rst), .abort(abort),
        .elem_push(elem_push), .elem_pattern(elem_pattern), .elem_mask(elem_mask),
        .elem_last(elem_last), .elem_bypass(elem_bypass),
        .trig_in(trig_in), .launch(launch), .armed(armed), .paused(paused)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: every launch pops one expected item (paused level after launch).
    always @(negedge clk) begin
        if (!rst && launch) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_err++;
                $display("FAIL R4 unexpected launch: actual=1 expected=0");
            end else begin
                check("R8", "paused after launch", 32'(paused), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_elem(input logic [W-1:0] pat, input logic [W-1:0] msk,
                             input logic fin, input logic byp);
        elem_push = 1'b1; elem_pattern = pat; elem_mask = msk;
        elem_last = fin; elem_bypass = byp;
        tick(1);
        elem_push = 1'b0;
    endtask

    task automatic do_abort();
        abort = 1'b1;
        tick(1);
        abort = 1'b0;
    endtask

    task automatic expect_launch(input string req, input logic [W-1:0] val, input bit paused_exp);
        trig_in = val;
        exp_q.push_back(paused_exp);
        tick(2);
        #1;
        check(req, "launch timing", 32'(launch), 32'd1);
        check(req, "expected launch consumed", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic expect_quiet(input string req, input int n);
        tick(n);
        #1;
        check(req, "no pending launch", 32'(exp_q.size()), 32'd0);
        check(req, "launch low", 32'(launch), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "launch after reset", 32'(launch), 0);
        check("R1", "armed after reset", 32'(armed), 0);
        check("R1", "paused after reset", 32'(paused), 0);

        // R3/R7: default single condition, bit 0 high
        push_elem(8'h01, 8'h01, 1'b1, 1'b0);
        check("R7", "armed after load", 32'(armed), 1);
        expect_launch("R3", 8'h01, 1'b0);
        check("R7", "armed after launch", 32'(armed), 0);

        // R3: held level does not satisfy a newly loaded stage; R8 paused
        push_elem(8'h01, 8'h01, 1'b1, 1'b0);
        check("R8", "paused after retrigger load", 32'(paused), 1);
        expect_quiet("R3", 5);
        trig_in = 8'h00;
        tick(1);
        expect_launch("R3", 8'h01, 1'b0);

        // R1: abort returns to idle
        do_abort();
        #1;
        check("R1", "armed after abort", 32'(armed), 0);
        check("R1", "paused after abort", 32'(paused), 0);

        // R2: unmasked bits ignored
        trig_in = 8'hF0;
        push_elem(8'hA5, 8'h0F, 1'b1, 1'b0);
        trig_in = 8'h04;
        expect_quiet("R2", 3);
        expect_launch("R2", 8'h35, 1'b0);
        do_abort();

        // R5/R4: two-stage chain 01 then 10
        trig_in = 8'h00;
        push_elem(8'h01, 8'h01, 1'b0, 1'b0);
        push_elem(8'h02, 8'h02, 1'b1, 1'b0);
        trig_in = 8'h02;
        expect_quiet("R4", 3);
        check("R7", "armed while chain waits", 32'(armed), 1);
        trig_in = 8'h01;
        expect_quiet("R4", 3);
        expect_launch("R5", 8'h02, 1'b0);
        do_abort();

        // R3/R4: both bits high at once clears only the first stage
        trig_in = 8'h00;
        push_elem(8'h01, 8'h01, 1'b0, 1'b0);
        push_elem(8'h02, 8'h02, 1'b1, 1'b0);
        trig_in = 8'h03;
        expect_quiet("R4", 4);
        trig_in = 8'h01;
        tick(1);
        expect_launch("R3", 8'h03, 1'b0);
        do_abort();

        // R6: bypass element launches without a match
        trig_in = 8'h00;
        exp_q.push_back(1'b0);
        push_elem(8'hFF, 8'hFF, 1'b1, 1'b1);
        tick(1);
        #1;
        check("R6", "bypass launch", 32'(launch), 1);
        check("R6", "bypass launch consumed", 32'(exp_q.size()), 0);
        do_abort();

        // R8: alternating retrigger conditions
        trig_in = 8'h00;
        for (int k = 0; k < 2; k++) begin
            push_elem(8'h01, 8'h01, 1'b1, 1'b0);
            push_elem(8'h02, 8'h02, 1'b1, 1'b0);
        end
        expect_launch("R8", 8'h01, 1'b1);
        expect_launch("R8", 8'h02, 1'b1);
        expect_launch("R8", 8'h01, 1'b1);
        expect_launch("R8", 8'h02, 1'b0);
        do_abort();

        // R10: fifth push into a full queue is ignored
        trig_in = 8'h00;
        for (int k = 0; k < 5; k++) push_elem(8'h01, 8'h01, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            trig_in = 8'h00;
            tick(1);
            expect_launch("R10", 8'h01, (k < 3));
        end
        trig_in = 8'h00;
        tick(1);
        trig_in = 8'h01;
        expect_quiet("R10", 3);
        check("R10", "paused after queue drained", 32'(paused), 0);
        do_abort();

        // R9: abort coincides with the completing closing stage
        trig_in = 8'h00;
        push_elem(8'h01, 8'h01, 1'b1, 1'b0);
        trig_in = 8'h01;
        tick(1);
        abort = 1'b1;
        tick(1);
        abort = 1'b0;
        expect_quiet("R9", 3);
        check("R9", "armed after coincident abort", 32'(armed), 0);
        trig_in = 8'h00;
        tick(1);
        trig_in = 8'h01;
        expect_quiet("R9", 3);

        // R9: push in the abort cycle is discarded
        trig_in = 8'h00;
        elem_push = 1'b1; elem_pattern = 8'h01; elem_mask = 8'h01;
        elem_last = 1'b1; elem_bypass = 1'b0; abort = 1'b1;
        tick(1);
        elem_push = 1'b0; abort = 1'b0;
        #1;
        check("R9", "armed after push with abort", 32'(armed), 0);
        trig_in = 8'h01;
        expect_quiet("R9", 4);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule